// File: doc/BRIEF.md
# Windowed Memory Bank-Switch Mapper

This block sits between an 8-bit CPU, a video fetch bus and two banked ROMs. It turns narrow CPU and video addresses into wide ROM page numbers. The CPU programs it through one indirect pair of write-only ports. The first is a select port. It names one of eight bank windows and carries two layout bits. The second is a data port. It loads a bank number into whichever window the select port last named. Repeated select writes replace the previous index. Nothing is stacked or queued. Software that can be interrupted between the select write and the data write must therefore save and restore the select value itself.

The program space has four 8 KB slots. Window 7 always feeds the second slot, and the top slot always holds the last ROM bank. Window 6 and the second-to-last bank take the first and third slots, and the program layout bit decides which goes where. The character space is 8 KB. One half is built from two 2 KB windows (0 and 1). The other half is built from four 1 KB windows (2 to 5). The character layout bit swaps the two halves.

Both page outputs are combinational from the current addresses and the stored registers. A register write takes effect at the clock edge that samples it.

Top module: `bank_mapper`

## Requirements
- R1: After synchronous reset, every bank window holds 0 and the select port holds index 0 with both layout bits clear. Program reads at $E000 therefore give page all-ones, reads at $C000 give all-ones minus 1, and reads at $8000 and $A000 give 0. Character reads at $0000 give page 0.
- R2: A write is decoded only when `cpu_we` is high with A15=1, A14=0 and A13=0. In that range A0=0 selects the select port and A0=1 selects the data port, so the whole range $8000–$9FFF mirrors the pair. Writes anywhere else change nothing.
- R3: A data write loads window[idx], where idx is the most recent select index. A new select write only replaces idx. Writing select 6, select 1, data $02 and data $03 leaves window 6 unchanged and window 1 holding $03.
- R4: A program read with A14:A13 = 01 ($A000–$BFFF) always uses window 7, whatever the layout bits are.
- R5: A program read with A14:A13 = 11 ($E000–$FFFF) always gives the last page (all ones).
- R6: The select byte's bit 6 is the program layout bit. When it is 0, $8000 uses window 6 and $C000 uses the second-to-last page. When it is 1, those two placements are swapped.
- R7: A program page is the low PRG_BANK_W bits of the stored 8-bit bank number.
- R8: The select byte's bit 7 is the character layout bit. When it is 0, video $0000–$07FF uses window 0 and $0800–$0FFF uses window 1. Video $1000, $1400, $1800 and $1C00 (1 KB each) use windows 2, 3, 4 and 5. The select byte's bits 2:0 are the window index.
- R9: When the character layout bit is 1, the two video halves exchange their window assignments.
- R10: A 2 KB window ignores bit 0 of its stored number. Its page is the stored number with bit 0 replaced by video A10.
- R11: The page outputs follow address changes with no clock. A register write shows on the outputs after the edge that samples it, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_we | input | 1 | CPU write strobe, sampled on the rising edge |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| ppu_addr | input | 13 | Video bus address within the 8 KB character space |
| prg_page | output | PRG_BANK_W (6) | 8 KB program ROM page for the current CPU address |
| chr_page | output | CHR_BANK_W (8) | 1 KB character ROM page for the current video address |

## Verification
Address-to-page results have no register on the way. The bench sets an address on the falling edge and reads the page 1 ns later, with no rising edge in between. A select or data write is due exactly one rising edge after it is presented. Every write is held across one rising edge and released on the next falling edge. The timing check reads the target page while the write is still pending and finds the old value, then reads it again after that single edge and finds the new one.

// File: rtl/bank_mapper_pkg.sv
package bank_mapper_pkg;

    localparam int WIN_COUNT  = 8;
    localparam int WIN_IDX_W  = $clog2(WIN_COUNT);
    localparam int BANK_REG_W = 8;
    localparam int CPU_ADDR_W = 16;
    localparam int VID_ADDR_W = 13;

    // windows with a fixed role in the program space
    localparam logic [WIN_IDX_W-1:0] WIN_PRG_MOVABLE = WIN_IDX_W'(6);
    localparam logic [WIN_IDX_W-1:0] WIN_PRG_SECOND  = WIN_IDX_W'(7);
    // first of the four 1 KB character windows
    localparam logic [WIN_IDX_W-1:0] WIN_CHR_FINE0   = WIN_IDX_W'(2);

    typedef logic [BANK_REG_W-1:0] bank_num_t;
    typedef bank_num_t [WIN_COUNT-1:0] bank_file_t;

    typedef struct packed {
        logic                 chr_swap;
        logic                 prg_swap;
        logic [WIN_IDX_W-1:0] idx;
    } sel_t;

    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_SEL  = 2'd1,
        OP_DATA = 2'd2
    } reg_op_e;

    typedef enum logic [1:0] {
        SLOT_LOW  = 2'd0,
        SLOT_MIDA = 2'd1,
        SLOT_MIDB = 2'd2,
        SLOT_TOP  = 2'd3
    } prg_slot_e;

    // register decode: A15=1, A14=0, A13=0, A0 picks the port
    function automatic reg_op_e decode_op(input logic we,
                                          input logic [CPU_ADDR_W-1:0] a);
        reg_op_e op;
        op = OP_NONE;
        if (we && a[15] && !a[14] && !a[13])
            op = a[0] ? OP_DATA : OP_SEL;
        return op;
    endfunction

    // layout bits sit at 7 (character) and 6 (program), index at 2:0
    function automatic sel_t unpack_sel(input bank_num_t d);
        sel_t s;
        s.chr_swap = d[7];
        s.prg_swap = d[6];
        s.idx      = d[WIN_IDX_W-1:0];
        return s;
    endfunction

    function automatic prg_slot_e cpu_slot(input logic [CPU_ADDR_W-1:0] a);
        return prg_slot_e'(a[14:13]);
    endfunction

    // character window feeding a video address
    function automatic logic [WIN_IDX_W-1:0] chr_window(
            input logic [VID_ADDR_W-1:0] va, input logic swap);
        logic coarse_half;
        logic [WIN_IDX_W-1:0] w;
        coarse_half = ~(va[12] ^ swap);
        if (coarse_half)
            w = {{(WIN_IDX_W-1){1'b0}}, va[11]};
        else
            w = WIN_CHR_FINE0 + {{(WIN_IDX_W-2){1'b0}}, va[11:10]};
        return w;
    endfunction

endpackage

// File: rtl/bank_regs.sv
module bank_regs
    import bank_mapper_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cpu_we,
    input  logic [CPU_ADDR_W-1:0] cpu_addr,
    input  bank_num_t             cpu_wdata,
    output sel_t                  sel_q,
    output bank_file_t            bank_q
);

    reg_op_e op;

    always_comb op = decode_op(cpu_we, cpu_addr);

    always_ff @(posedge clk) begin
        if (rst)
            sel_q <= '0;
        else if (op == OP_SEL)
            sel_q <= unpack_sel(cpu_wdata);
    end

    generate
        for (genvar w = 0; w < WIN_COUNT; w++) begin : g_win
            always_ff @(posedge clk) begin
                if (rst)
                    bank_q[w] <= '0;
                else if (op == OP_DATA && sel_q.idx == WIN_IDX_W'(w))
                    bank_q[w] <= cpu_wdata;
            end
        end
    endgenerate

    // R3: a select write replaces the index held for later data writes
    p_sel_load_r3: assert property (@(posedge clk) disable iff (rst)
        (op == OP_SEL) |=> (sel_q.idx == $past(cpu_wdata[WIN_IDX_W-1:0])));

    // R3: a data write lands in the window named by the latest select
    p_data_load_r3: assert property (@(posedge clk) disable iff (rst)
        (op == OP_DATA) |=> (bank_q[$past(sel_q.idx)] == $past(cpu_wdata)));

    // R2: without a decoded write nothing changes
    p_hold_idle_r2: assert property (@(posedge clk) disable iff (rst)
        (op == OP_NONE) |=> ($stable(bank_q) && $stable(sel_q)));

    // R3: a select write never touches the bank windows
    p_sel_keeps_banks_r3: assert property (@(posedge clk) disable iff (rst)
        (op == OP_SEL) |=> $stable(bank_q));

endmodule

// File: rtl/prg_window_map.sv
module prg_window_map
    import bank_mapper_pkg::*;
#(
    parameter int PRG_BANK_W = 6
)(
    input  sel_t                  sel_q,
    input  bank_file_t            bank_q,
    input  logic [CPU_ADDR_W-1:0] cpu_addr,
    output logic [PRG_BANK_W-1:0] prg_page
);

    localparam logic [PRG_BANK_W-1:0] PAGE_LAST   = '1;
    localparam logic [PRG_BANK_W-1:0] PAGE_PENULT = PAGE_LAST - PRG_BANK_W'(1);

    prg_slot_e             slot;
    logic [PRG_BANK_W-1:0] movable_page;
    logic [PRG_BANK_W-1:0] second_page;

    always_comb begin
        slot         = cpu_slot(cpu_addr);
        movable_page = bank_q[WIN_PRG_MOVABLE][PRG_BANK_W-1:0];
        second_page  = bank_q[WIN_PRG_SECOND][PRG_BANK_W-1:0];
        unique case (slot)
            SLOT_LOW:  prg_page = sel_q.prg_swap ? PAGE_PENULT : movable_page;
            SLOT_MIDA: prg_page = second_page;
            SLOT_MIDB: prg_page = sel_q.prg_swap ? movable_page : PAGE_PENULT;
            SLOT_TOP:  prg_page = PAGE_LAST;
        endcase
    end

    // R5, R6: the two fixed pages never both appear in movable slots
    always_comb begin
        if (slot == SLOT_TOP)
            p_top_fixed_r5: assert (&prg_page);
        if (slot == SLOT_LOW || slot == SLOT_MIDB)
            p_swap_pair_r6: assert ((prg_page == PAGE_PENULT) ||
                                    (prg_page == movable_page));
    end

endmodule

// File: rtl/chr_window_map.sv
module chr_window_map
    import bank_mapper_pkg::*;
#(
    parameter int CHR_BANK_W = 8
)(
    input  sel_t                  sel_q,
    input  bank_file_t            bank_q,
    input  logic [VID_ADDR_W-1:0] ppu_addr,
    output logic [CHR_BANK_W-1:0] chr_page
);

    logic [WIN_IDX_W-1:0]  win;
    logic                  coarse;
    logic [CHR_BANK_W-1:0] stored;

    always_comb begin
        win    = chr_window(ppu_addr, sel_q.chr_swap);
        coarse = (win < WIN_CHR_FINE0);
        stored = bank_q[win][CHR_BANK_W-1:0];
    end

    generate
        if (CHR_BANK_W > 1) begin : g_wide
            always_comb
                chr_page = coarse ? {stored[CHR_BANK_W-1:1], ppu_addr[10]} : stored;
        end else begin : g_narrow
            always_comb
                chr_page = coarse ? ppu_addr[10] : stored;
        end
    endgenerate

    // R10: inside a 2 KB window the page low bit is video A10
    // R9: the half read at A12 xor swap decides the window size
    always_comb begin
        if (ppu_addr[12] == sel_q.chr_swap)
            p_pair_low_bit_r10: assert (chr_page[0] == ppu_addr[10]);
        else
            p_fine_window_r9: assert (win >= WIN_CHR_FINE0);
    end

endmodule

// File: rtl/bank_mapper.sv
module bank_mapper
    import bank_mapper_pkg::*;
#(
    parameter int PRG_BANK_W = 6,
    parameter int CHR_BANK_W = 8
)(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cpu_we,
    input  logic [15:0]           cpu_addr,
    input  logic [7:0]            cpu_wdata,
    input  logic [12:0]           ppu_addr,
    output logic [PRG_BANK_W-1:0] prg_page,
    output logic [CHR_BANK_W-1:0] chr_page
);

    sel_t       sel_q;
    bank_file_t bank_q;

    bank_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .cpu_we    (cpu_we),
        .cpu_addr  (cpu_addr),
        .cpu_wdata (cpu_wdata),
        .sel_q     (sel_q),
        .bank_q    (bank_q)
    );

    prg_window_map #(.PRG_BANK_W(PRG_BANK_W)) u_prg (
        .sel_q    (sel_q),
        .bank_q   (bank_q),
        .cpu_addr (cpu_addr),
        .prg_page (prg_page)
    );

    chr_window_map #(.CHR_BANK_W(CHR_BANK_W)) u_chr (
        .sel_q    (sel_q),
        .bank_q   (bank_q),
        .ppu_addr (ppu_addr),
        .chr_page (chr_page)
    );

    // R4: the $A000 slot follows the last data write aimed at window 7
    p_win7_r4: assert property (@(posedge clk) disable iff (rst)
        (cpu_addr[14:13] == 2'b01 && $stable(cpu_addr) && $past(u_regs.op) == OP_NONE)
        |-> $stable(prg_page));

endmodule

// File: tb/bank_mapper_test.sv
`timescale 1ns/100ps
module bank_mapper_test;

    localparam int PW = 6;
    localparam int CW = 8;
    localparam logic [1:0] K_W = 2'd0, K_P = 2'd1, K_C = 2'd2;
    localparam int NV = 63;

    // {kind, address, data-or-expected, requirement}
    localparam logic [29:0] VEC [NV] = '{
        {K_P, 16'hE000, 8'h3F, 4'd5},   // R5 after reset
        {K_P, 16'h8000, 8'h00, 4'd1},   // R1
        {K_P, 16'hC000, 8'h3E, 4'd1},   // R1
        {K_C, 16'h0000, 8'h00, 4'd1},   // R1
        {K_W, 16'h8000, 8'h06, 4'd0},
        {K_W, 16'h8001, 8'h05, 4'd0},
        {K_P, 16'h8000, 8'h05, 4'd6},   // R6 layout bit clear
        {K_P, 16'hC000, 8'h3E, 4'd6},
        {K_W, 16'h8000, 8'h07, 4'd0},
        {K_W, 16'h8001, 8'h12, 4'd0},
        {K_P, 16'hA000, 8'h12, 4'd4},   // R4
        {K_W, 16'h8000, 8'h46, 4'd0},
        {K_P, 16'hC000, 8'h05, 4'd6},   // R6 layout bit set
        {K_P, 16'h8000, 8'h3E, 4'd6},
        {K_P, 16'hFFFF, 8'h3F, 4'd5},   // R5
        {K_W, 16'h8000, 8'h46, 4'd0},   // R3 select 6, select 1, data 2, data 3
        {K_W, 16'h8000, 8'h41, 4'd0},
        {K_W, 16'h8001, 8'h02, 4'd0},
        {K_W, 16'h8001, 8'h03, 4'd0},
        {K_P, 16'hC000, 8'h05, 4'd3},
        {K_C, 16'h0800, 8'h02, 4'd3},
        {K_C, 16'h0C00, 8'h03, 4'd3},
        {K_W, 16'h8000, 8'h47, 4'd0},
        {K_W, 16'h8001, 8'hC9, 4'd0},
        {K_P, 16'hA000, 8'h09, 4'd7},   // R7 truncation
        {K_W, 16'hA000, 8'h07, 4'd0},   // R2 undecoded writes
        {K_W, 16'hA001, 8'hFF, 4'd0},
        {K_W, 16'hC001, 8'hFF, 4'd0},
        {K_W, 16'h0001, 8'hFF, 4'd0},
        {K_P, 16'hA000, 8'h09, 4'd2},
        {K_P, 16'hC000, 8'h05, 4'd2},
        {K_W, 16'h8FFF, 8'h21, 4'd0},   // R2 mirrored data port
        {K_P, 16'hA000, 8'h21, 4'd2},
        {K_W, 16'h9FFE, 8'h40, 4'd0},   // R2 mirrored select port
        {K_W, 16'h8001, 8'h10, 4'd0},
        {K_W, 16'h8000, 8'h42, 4'd0},
        {K_W, 16'h8001, 8'h22, 4'd0},
        {K_W, 16'h8000, 8'h43, 4'd0},
        {K_W, 16'h8001, 8'h33, 4'd0},
        {K_W, 16'h8000, 8'h44, 4'd0},
        {K_W, 16'h8001, 8'h44, 4'd0},
        {K_W, 16'h8000, 8'h45, 4'd0},
        {K_W, 16'h8001, 8'h55, 4'd0},
        {K_C, 16'h0000, 8'h10, 4'd8},   // R8 layout
        {K_C, 16'h0400, 8'h11, 4'd8},
        {K_C, 16'h0800, 8'h02, 4'd8},
        {K_C, 16'h0C00, 8'h03, 4'd8},
        {K_C, 16'h1000, 8'h22, 4'd8},
        {K_C, 16'h1400, 8'h33, 4'd8},
        {K_C, 16'h1800, 8'h44, 4'd8},
        {K_C, 16'h1C00, 8'h55, 4'd8},
        {K_W, 16'h8000, 8'h40, 4'd0},
        {K_W, 16'h8001, 8'h11, 4'd0},
        {K_C, 16'h0000, 8'h10, 4'd10},  // R10 low bit ignored
        {K_C, 16'h0400, 8'h11, 4'd10},
        {K_W, 16'h8000, 8'h80, 4'd0},
        {K_C, 16'h1000, 8'h10, 4'd9},   // R9 swapped halves
        {K_C, 16'h1400, 8'h11, 4'd9},
        {K_C, 16'h1800, 8'h02, 4'd9},
        {K_C, 16'h1C00, 8'h03, 4'd9},
        {K_C, 16'h0000, 8'h22, 4'd9},
        {K_C, 16'h0C00, 8'h55, 4'd9},
        {K_P, 16'h8000, 8'h05, 4'd6}    // R6 layout bit back to 0
    };

    logic          clk = 1'b0;
    logic          rst;
    logic          cpu_we;
    logic [15:0]   cpu_addr;
    logic [7:0]    cpu_wdata;
    logic [12:0]   ppu_addr;
    logic [PW-1:0] prg_page;
    logic [CW-1:0] chr_page;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    bank_mapper #(.PRG_BANK_W(PW), .CHR_BANK_W(CW)) uut (
        .clk(clk), .rst(rst), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .ppu_addr(ppu_addr),
        .prg_page(prg_page), .chr_page(chr_page)
    );

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic cpu_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_we = 1'b1; cpu_addr = a; cpu_wdata = d;
        @(negedge clk);
        cpu_we = 1'b0;
    endtask

    task automatic prg_probe(input logic [15:0] a, output logic [7:0] got);
        @(negedge clk);
        cpu_addr = a;
        #1 got = {2'b00, prg_page};
    endtask

    task automatic chr_probe(input logic [12:0] a, output logic [7:0] got);
        @(negedge clk);
        ppu_addr = a;
        #1 got = chr_page;
    endtask

    initial begin
        logic [7:0] got;
        rst = 1'b1; cpu_we = 1'b0; cpu_addr = '0; cpu_wdata = '0; ppu_addr = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            logic [1:0]  kind;
            logic [15:0] a;
            logic [7:0]  d;
            kind = VEC[i][29:28];
            a    = VEC[i][27:12];
            d    = VEC[i][11:4];
            if (kind == K_W) cpu_write(a, d);
            else if (kind == K_P) begin
                prg_probe(a, got);
                check($sformatf("R%0d vec %0d", VEC[i][3:0], i), got, d);
            end else begin
                chr_probe(a[12:0], got);
                check($sformatf("R%0d vec %0d", VEC[i][3:0], i), got, d);
            end
        end

        // R11: the write shows only after its sampling edge
        cpu_write(16'h8000, 8'h03);
        @(negedge clk);
        ppu_addr = 13'h1400;
        cpu_we = 1'b1; cpu_addr = 16'h8001; cpu_wdata = 8'h7A;
        #1 check("R11 before edge", chr_page, 8'h33);
        @(negedge clk);
        cpu_we = 1'b0;
        #1 check("R11 after edge", chr_page, 8'h7A);
        // R11: address change alone updates the page
        ppu_addr = 13'h1800;
        #1 check("R11 comb address", chr_page, 8'h44);

        // R1: reset mid-run clears everything
        @(negedge clk); rst = 1'b1;
        @(negedge clk); @(negedge clk); rst = 1'b0;
        prg_probe(16'hA000, got); check("R1 reset win7", got, 8'h00);
        prg_probe(16'h8000, got); check("R1 reset layout", got, 8'h00);
        prg_probe(16'hE000, got); check("R1 reset top", got, 8'h3F);
        chr_probe(13'h1400, got); check("R1 reset chr", got, 8'h00);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog got timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule